// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a bank of hardware semaphore flags that two agents, a left port and a right port, use to coordinate access to a shared resource. Each port picks one semaphore with an index. A write with the data bit at 0 asks for the token. A write with the data bit at 1 gives it back, or withdraws a request that is still waiting. A read returns that semaphore's state as seen from the reading port, copied onto every bit of the read bus.

When a port asks for a token that the other side holds, the request is not dropped. It is recorded as pending. When the holder gives the token back, it passes straight to the waiting port with no further action from software. If both ports ask for a free semaphore in the same cycle, the left port wins and the right request is kept as pending.

Writes take effect at the clock edge. The read bus is combinational from the registered state, so it shows the outcome of a write from the cycle after that write.

Top module: `semBank`

## Requirements
- R1: After reset every semaphore is free and no request is pending, so both ports read 0xFFFF at every index.
- R2: A read returns 0x0000 when the reading port holds the indexed semaphore. In every other case it returns 0xFFFF. The read bus only ever shows these two values.
- R3: A write with data bit 0 (the request value) to a free semaphore grants it to the writer. From the next cycle the writer reads 0x0000 and the other port reads 0xFFFF. The two ports never hold the same semaphore at once.
- R4: A read access (enable high, write low) leaves all ownership and pending state unchanged.
- R5: A request for a semaphore held by the other port leaves the holder in place. The requester keeps reading 0xFFFF, and the request is recorded as pending.
- R6: When the holder writes 1 (the release value) while the other port has a pending request, the waiting port owns the semaphore from the next cycle and reads 0x0000. The former holder reads 0xFFFF.
- R7: When the holder releases and no request is pending, the semaphore becomes free.
- R8: A port with a pending request that writes 1 cancels that request. A later release by the holder then leaves the semaphore free.
- R9: When both ports request the same free semaphore in one cycle, the left port is granted and the right request becomes pending.
- R10: Operations on one index do not change the state of any other index.
- R11: A cycle with enable low has no effect, whatever the write and data inputs are.
- R12: When the holder releases in the same cycle that the other port requests, the requesting port owns the semaphore from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lEn | input | 1 | Left port access enable |
| lWe | input | 1 | Left port write (1) or read (0) |
| lIdx | input | IDX_W (3) | Left port semaphore index |
| lWbit | input | 1 | Left port write value: 0 request, 1 release or cancel |
| lRdata | output | DATA_W (16) | Left port view of the indexed semaphore |
| rEn | input | 1 | Right port access enable |
| rWe | input | 1 | Right port write (1) or read (0) |
| rIdx | input | IDX_W (3) | Right port semaphore index |
| rWbit | input | 1 | Right port write value: 0 request, 1 release or cancel |
| rRdata | output | DATA_W (16) | Right port view of the indexed semaphore |

## Verification
The bench targets the handover cases. The first is a release while the other side is waiting. A design that drops losing requests leaves the semaphore free there, so the waiter reads 0xFFFF. The second is a same-cycle release and request. A design that looks only at stored pending bits misses this request. The bench also checks the left-wins tie on a free semaphore, where a wrong priority shows the token on the right. It checks cancellation of a pending request, where a stale pending bit would hand the token to a port that has given up. Finally, it mixes read-only accesses, disabled cycles and work on other indices among these cases, to catch state changing when it should not.

// File: rtl/semPkg.sv
package semPkg;

  // Who holds one semaphore
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } ownerE;

  // Per-semaphore strobes from the access decode to the state cells
  typedef struct packed {
    logic reqL;   // left writes 0 to this semaphore
    logic relL;   // left writes 1 to this semaphore
    logic reqR;   // right writes 0 to this semaphore
    logic relR;   // right writes 1 to this semaphore
  } semStrobeS;

endpackage

// File: rtl/semCtrl.sv
module semCtrl
  import semPkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = 3
) (
  input  logic             lEn,
  input  logic             lWe,
  input  logic [IDX_W-1:0] lIdx,
  input  logic             lWbit,
  input  logic             rEn,
  input  logic             rWe,
  input  logic [IDX_W-1:0] rIdx,
  input  logic             rWbit,
  output semStrobeS        strobes [NUM_SEM]
);

  logic lWrite, rWrite;
  assign lWrite = lEn && lWe;
  assign rWrite = rEn && rWe;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
    logic lHit, rHit;
    assign lHit = lWrite && (lIdx == IDX_W'(g));
    assign rHit = rWrite && (rIdx == IDX_W'(g));
    assign strobes[g].reqL = lHit && !lWbit;
    assign strobes[g].relL = lHit &&  lWbit;
    assign strobes[g].reqR = rHit && !rWbit;
    assign strobes[g].relR = rHit &&  rWbit;
  end

endmodule

// File: rtl/semCell.sv
module semCell
  import semPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  semStrobeS stb,
  output logic      ownL,
  output logic      ownR,
  output logic      pendL,
  output logic      pendR
);

  ownerE ownQ, ownD;
  logic  pLQ, pRQ, pLD, pRD;
  logic  pLEff, pREff;

  always_comb begin
    // A pending request as it stands after this cycle's writes
    pLEff = stb.reqL | (pLQ & ~stb.relL);
    pREff = stb.reqR | (pRQ & ~stb.relR);
    ownD  = ownQ;
    pLD   = 1'b0;
    pRD   = 1'b0;
    case (ownQ)
      OWN_LEFT: begin
        if (stb.relL) ownD = pREff ? OWN_RIGHT : OWN_NONE;
        else          pRD  = pREff;
      end
      OWN_RIGHT: begin
        if (stb.relR) ownD = pLEff ? OWN_LEFT : OWN_NONE;
        else          pLD  = pLEff;
      end
      default: begin
        if (stb.reqL) begin
          ownD = OWN_LEFT;
          pRD  = stb.reqR;   // tie: left wins, right waits
        end else if (stb.reqR) begin
          ownD = OWN_RIGHT;
        end else begin
          ownD = OWN_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownQ <= OWN_NONE;
      pLQ  <= 1'b0;
      pRQ  <= 1'b0;
    end else begin
      ownQ <= ownD;
      pLQ  <= pLD;
      pRQ  <= pRD;
    end
  end

  assign ownL  = (ownQ == OWN_LEFT);
  assign ownR  = (ownQ == OWN_RIGHT);
  assign pendL = pLQ;
  assign pendR = pRQ;

endmodule

// File: rtl/semCore.sv
module semCore
  import semPkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  semStrobeS          strobes [NUM_SEM],
  input  logic [IDX_W-1:0]   lIdx,
  input  logic [IDX_W-1:0]   rIdx,
  output logic [NUM_SEM-1:0] ownL,
  output logic [NUM_SEM-1:0] ownR,
  output logic [NUM_SEM-1:0] pendL,
  output logic [NUM_SEM-1:0] pendR,
  output logic [DATA_W-1:0]  lRdata,
  output logic [DATA_W-1:0]  rRdata
);

  logic [NUM_SEM-1:0] lSel, rSel;
  logic lHeld, rHeld;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
    semCell u_cell (
      .clk   (clk),
      .rstN  (rstN),
      .stb   (strobes[g]),
      .ownL  (ownL[g]),
      .ownR  (ownR[g]),
      .pendL (pendL[g]),
      .pendR (pendR[g])
    );
    assign lSel[g] = (lIdx == IDX_W'(g));
    assign rSel[g] = (rIdx == IDX_W'(g));
  end

  // An index with no cell selects nothing and reads as free
  assign lHeld  = |(lSel & ownL);
  assign rHeld  = |(rSel & ownR);
  assign lRdata = {DATA_W{~lHeld}};
  assign rRdata = {DATA_W{~rHeld}};

endmodule

// File: rtl/semBank.sv
module semBank
  import semPkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lEn,
  input  logic              lWe,
  input  logic [IDX_W-1:0]  lIdx,
  input  logic              lWbit,
  output logic [DATA_W-1:0] lRdata,
  input  logic              rEn,
  input  logic              rWe,
  input  logic [IDX_W-1:0]  rIdx,
  input  logic              rWbit,
  output logic [DATA_W-1:0] rRdata
);

  semStrobeS          strobes [NUM_SEM];
  logic [NUM_SEM-1:0] ownL, ownR, pendL, pendR;

  semCtrl #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_ctrl (
    .lEn(lEn), .lWe(lWe), .lIdx(lIdx), .lWbit(lWbit),
    .rEn(rEn), .rWe(rWe), .rIdx(rIdx), .rWbit(rWbit),
    .strobes(strobes)
  );

  semCore #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lIdx(lIdx), .rIdx(rIdx),
    .ownL(ownL), .ownR(ownR), .pendL(pendL), .pendR(pendR),
    .lRdata(lRdata), .rRdata(rRdata)
  );

endmodule

// File: rtl/semChecker.sv
module semChecker #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               lEn,
  input logic               lWe,
  input logic [IDX_W-1:0]   lIdx,
  input logic               lWbit,
  input logic [DATA_W-1:0]  lRdata,
  input logic               rEn,
  input logic               rWe,
  input logic [IDX_W-1:0]   rIdx,
  input logic               rWbit,
  input logic [DATA_W-1:0]  rRdata,
  input logic [NUM_SEM-1:0] ownL,
  input logic [NUM_SEM-1:0] ownR,
  input logic [NUM_SEM-1:0] pendL,
  input logic [NUM_SEM-1:0] pendR
);

  logic lWr, rWr, sameIdx;
  assign lWr     = lEn && lWe;
  assign rWr     = rEn && rWe;
  assign sameIdx = (lIdx == rIdx);

  // R1: the first cycle out of reset shows everything free
  p_reset_free_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (ownL == '0) && (ownR == '0) && (pendL == '0) && (pendR == '0));

  // R2: the read buses carry only the two replicated values
  p_read_values_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((lRdata == '0) || (lRdata == '1)) && ((rRdata == '0) || (rRdata == '1)));

  // R3: ownership is exclusive
  p_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ownL & ownR) == '0);

  // R5: a request against the left holder waits and does not steal
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rWr && !rWbit && ownL[rIdx] && !(lWr && sameIdx))
    |=> ownL[$past(rIdx)] && pendR[$past(rIdx)]);

  // R6: a left release with the right side waiting hands over
  p_handover_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lWr && lWbit && ownL[lIdx] && pendR[lIdx] && !(rWr && sameIdx))
    |=> ownR[$past(lIdx)]);

  // R7: a left release with nobody waiting frees the semaphore
  p_free_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lWr && lWbit && ownL[lIdx] && !pendR[lIdx] && !(rWr && sameIdx))
    |=> !ownL[$past(lIdx)] && !ownR[$past(lIdx)]);

  // R9: a same-cycle request on a free semaphore goes to the left
  p_tie_left_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lWr && !lWbit && rWr && !rWbit && sameIdx && !ownL[lIdx] && !ownR[lIdx])
    |=> ownL[$past(lIdx)] && pendR[$past(lIdx)]);

  // R11 and R4: cycles without a write leave the state alone
  p_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!lWr && !rWr) |=> $stable(ownL) && $stable(ownR) && $stable(pendL) && $stable(pendR));

  // R12: a release meeting an opposing request grants the requester
  p_swap_r12: assert property (@(posedge clk) disable iff (!rstN)
    (lWr && lWbit && ownL[lIdx] && rWr && !rWbit && sameIdx)
    |=> ownR[$past(lIdx)]);

endmodule

bind semBank semChecker #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_semChecker (.*);

// File: tb/test_semBank.sv
module test_semBank;

  localparam logic [15:0] HELD = 16'h0000;
  localparam logic [15:0] NONE = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lEn = 1'b0, lWe = 1'b0, lWbit = 1'b0;
  logic        rEn = 1'b0, rWe = 1'b0, rWbit = 1'b0;
  logic [2:0]  lIdx = '0, rIdx = '0;
  logic [15:0] lRdata, rRdata;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    bit          right;
    int          idx;
    logic [15:0] exp;
    int          req;
  } itemT;
  itemT q[$];

  always #5 clk = ~clk;

  semBank i_semBank (
    .clk(clk), .rstN(rstN),
    .lEn(lEn), .lWe(lWe), .lIdx(lIdx), .lWbit(lWbit), .lRdata(lRdata),
    .rEn(rEn), .rWe(rWe), .rIdx(rIdx), .rWbit(rWbit), .rRdata(rRdata)
  );

  // Monitor: pops expected reads in the low half of the cycle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      itemT it;
      logic [15:0] act;
      it  = q.pop_front();
      act = it.right ? rRdata : lRdata;
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL R%0d %s idx %0d: actual %h expected %h",
                 it.req, it.right ? "right" : "left", it.idx, act, it.exp);
      end
    end
  end

  task automatic drive(input bit le, input bit lw, input int li, input bit lb,
                       input bit re, input bit rw, input int ri, input bit rb);
    @(posedge clk); #1;
    lEn = le; lWe = lw; lIdx = 3'(li); lWbit = lb;
    rEn = re; rWe = rw; rIdx = 3'(ri); rWbit = rb;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic lWr(input int i, input bit b);
    drive(1, 1, i, b, 0, 0, 0, 0);
  endtask

  task automatic rWr(input int i, input bit b);
    drive(0, 0, 0, 0, 1, 1, i, b);
  endtask

  // Both ports read index i in one cycle
  task automatic rd2(input int i, input logic [15:0] eL, input logic [15:0] eR, input int req);
    drive(1, 0, i, 0, 1, 0, i, 0);
    q.push_back('{1'b0, i, eL, req});
    q.push_back('{1'b1, i, eR, req});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: everything free after reset
    for (int i = 0; i < 8; i++) rd2(i, NONE, NONE, 1);

    // R3, R2: left takes free idx 2
    lWr(2, 0);
    rd2(2, HELD, NONE, 3);
    // R5: right asks for it, left keeps it
    rWr(2, 0);
    rd2(2, HELD, NONE, 5);
    // R6: left releases, waiting right owns at once
    lWr(2, 1);
    rd2(2, NONE, HELD, 6);
    // R8: left waits, then cancels; right release frees it
    lWr(2, 0);
    rd2(2, NONE, HELD, 5);
    lWr(2, 1);
    rd2(2, NONE, HELD, 8);
    rWr(2, 1);
    rd2(2, NONE, NONE, 8);

    // R7: right takes idx 3 and gives it back with nobody waiting
    rWr(3, 0);
    rd2(3, NONE, HELD, 3);
    rWr(3, 1);
    rd2(3, NONE, NONE, 7);

    // R9: same-cycle request on free idx 6, left wins, right pending
    drive(1, 1, 6, 0, 1, 1, 6, 0);
    rd2(6, HELD, NONE, 9);
    lWr(6, 1);
    rd2(6, NONE, HELD, 9);
    rWr(6, 1);
    rd2(6, NONE, NONE, 7);

    // R10: left holds idx 0, right takes idx 1; neither disturbs the other
    lWr(0, 0);
    rWr(1, 0);
    rd2(0, HELD, NONE, 10);
    rd2(1, NONE, HELD, 10);
    rd2(4, NONE, NONE, 10);

    // R11: disabled write to idx 7 and to held idx 0 do nothing
    drive(0, 1, 7, 0, 0, 1, 7, 0);
    drive(0, 1, 0, 1, 0, 1, 0, 0);
    rd2(7, NONE, NONE, 11);
    rd2(0, HELD, NONE, 11);

    // R4: repeated read accesses leave ownership alone
    drive(1, 0, 0, 1, 1, 0, 0, 0);
    drive(1, 0, 0, 0, 1, 0, 0, 1);
    rd2(0, HELD, NONE, 4);

    // R12: left releases idx 0 as right requests it in the same cycle
    drive(1, 1, 0, 1, 1, 1, 0, 0);
    rd2(0, NONE, HELD, 12);
    rd2(1, NONE, HELD, 10);

    idle();
    idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule